// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a test access port controller with a boundary-scan register placed around a small set of pins. A serial test clock, a mode-select line and a serial data input steer the standard sixteen-state controller. Instructions and data are shifted through a single serial output. The chain has one capture stage for every input-only pin. Every bidirectional pin gets two capture stages, one for its data value and one for its output-enable value, and each of those has an update stage behind it.

Five instructions are decoded. IDCODE shifts out a fixed 32-bit identification word. BYPASS inserts a single stage. SAMPLE/PRELOAD captures pin and core values and loads the update stages, but leaves the pins under core control. EXTEST hands the pad data and pad enables to the update stages. HIGHZ switches every pad driver off and selects the bypass stage.

There is no asynchronous test-reset pin. The controller returns to its reset state either through the power-up reset or by holding the mode-select line high. A parameter lets an undriven mode-select or data input read as high, which models a pull-up.

Top module: `bscan_tap`

## Requirements
- R1: While `por_n` is low, the controller sits in Test-Logic-Reset. In that state `tdo_en` is 0, the active instruction is IDCODE, and `pad_out`/`pad_oe` follow `core_out`/`core_oe`.
- R2: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. Being in that state restores IDCODE as the active instruction, so every pad returns to core control.
- R3: The instruction register is 4 bits wide and is shifted with the LSB first. Capture-IR loads 4'b0001. The new instruction takes effect on the falling TCK edge in Update-IR. The opcodes are EXTEST 4'b0000, IDCODE 4'b0001, SAMPLE/PRELOAD 4'b0010, HIGHZ 4'b0011 and BYPASS 4'b1111.
- R4: Under IDCODE, the data path is a 32-bit register. Capture-DR loads the parameter `ID_CODE` into it with bit 0 forced to 1, and the word shifts out LSB first.
- R5: Under BYPASS, and under any opcode not listed in R3, the data path is one stage that captures 0. TDI therefore reappears on TDO one shift later.
- R6: In Capture-DR under SAMPLE/PRELOAD or EXTEST, the boundary register loads the following values. Bit i (i < N_IN) takes `in_pin[i]`. Bit N_IN+2j takes `bidi_in[j]`, and bit N_IN+2j+1 takes `core_oe[j]`. Bit 0 is nearest TDO, and a bit shifted in first ends at bit 0.
- R7: Under SAMPLE/PRELOAD, Update-DR copies bit N_IN+2j into the data update stage of pin j and bit N_IN+2j+1 into its enable update stage. During that instruction the pads stay at the core values.
- R8: Under EXTEST, `pad_out[j]` and `pad_oe[j]` come from the update stages. Those stages change only on the falling TCK edge in Update-DR, so shifting and pausing leave the pads unchanged.
- R9: Under HIGHZ, every `pad_oe` bit is 0, `pad_out` follows `core_out`, and the data path is the single bypass stage.
- R10: TDO and `tdo_en` change on falling TCK edges. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Driver enable for TDO (0 means high impedance) |
| in_pin | input | N_IN | Levels on the input-only pins |
| bidi_in | input | N_BIDI | Levels seen on the bidirectional pins |
| core_out | input | N_BIDI | Output data from the core logic |
| core_oe | input | N_BIDI | Output enables from the core logic |
| pad_out | output | N_BIDI | Data sent to the bidirectional pad drivers |
| pad_oe | output | N_BIDI | Enables sent to the bidirectional pad drivers |

## Verification
The serial path is exercised with several instruction patterns. The IDCODE word shows that the bit order is correct and that bit 0 is forced to 1. Bypass patterns of alternating ones and zeros expose a missing or doubled delay stage, and an unassigned opcode must produce the same result as BYPASS. Boundary scans use pin, core-enable and preload values that are deliberately asymmetric, so that a swapped data/enable stage or a reversed chain order shows up in the captured bits and at the pads. In an EXTEST scan the controller is parked in Pause-DR before Update-DR, which separates update on the falling edge in Update-DR from an update that happens early during shifting.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int unsigned IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0011;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_BOUNDARY
    } dr_sel_e;

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RESET:  st_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   st_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  st_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: st_d = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  st_d = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: st_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: st_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: st_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  st_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: st_d = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  st_d = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: st_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: st_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign state = st_q;

endmodule

// File: rtl/bscan_cells.sv
module bscan_cells #(
    parameter int unsigned N_IN   = 2,
    parameter int unsigned N_BIDI = 2
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              upd_en,
    input  logic              ext_mode,
    input  logic              hiz_mode,
    input  logic              tdi,
    input  logic [N_IN-1:0]   in_pin,
    input  logic [N_BIDI-1:0] bidi_in,
    input  logic [N_BIDI-1:0] core_out,
    input  logic [N_BIDI-1:0] core_oe,
    output logic              so,
    output logic [N_BIDI-1:0] pad_out,
    output logic [N_BIDI-1:0] pad_oe,
    output logic [N_BIDI-1:0] upd_data,
    output logic [N_BIDI-1:0] upd_oe
);

    localparam int unsigned LEN = N_IN + 2 * N_BIDI;

    typedef struct packed {
        logic [N_BIDI-1:0] dat;
        logic [N_BIDI-1:0] oe;
    } hold_t;

    logic [LEN-1:0]    snap;
    logic [LEN-1:0]    chain_d, chain_q;
    logic [N_BIDI-1:0] chain_dat, chain_oe;
    hold_t             hold_d, hold_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
        assign snap[i] = in_pin[i];
    end

    for (genvar j = 0; j < N_BIDI; j++) begin : g_bidi_cell
        assign snap[N_IN + 2*j]     = bidi_in[j];
        assign snap[N_IN + 2*j + 1] = core_oe[j];
        assign chain_dat[j]         = chain_q[N_IN + 2*j];
        assign chain_oe[j]          = chain_q[N_IN + 2*j + 1];
    end

    always_comb begin
        chain_d = chain_q;
        if (cap_en)        chain_d = snap;
        else if (shift_en) chain_d = {tdi, chain_q[LEN-1:1]};
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    always_comb begin
        hold_d = hold_q;
        if (upd_en) begin
            hold_d.dat = chain_dat;
            hold_d.oe  = chain_oe;
        end
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign so       = chain_q[0];
    assign upd_data = hold_q.dat;
    assign upd_oe   = hold_q.oe;
    assign pad_out  = ext_mode ? hold_q.dat : core_out;
    assign pad_oe   = hiz_mode ? '0 : (ext_mode ? hold_q.oe : core_oe);

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
    import bscan_pkg::*;
#(
    parameter int unsigned N_IN      = 2,
    parameter int unsigned N_BIDI    = 2,
    parameter logic [31:0] ID_CODE   = 32'h0A5C_1F3E,
    parameter bit          PULLUP_EN = 1'b1
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_en,
    input  logic [N_IN-1:0]   in_pin,
    input  logic [N_BIDI-1:0] bidi_in,
    input  logic [N_BIDI-1:0] core_out,
    input  logic [N_BIDI-1:0] core_oe,
    output logic [N_BIDI-1:0] pad_out,
    output logic [N_BIDI-1:0] pad_oe
);

    localparam logic [31:0] ID_WORD = ID_CODE | 32'd1;

    typedef struct packed {
        logic [IR_W-1:0] ir_sh;
        logic [31:0]     idsr;
        logic            byp;
    } rise_t;

    typedef struct packed {
        logic [IR_W-1:0] ir;
        logic            tdo;
        logic            tdo_en;
    } fall_t;

    logic              tms_i, tdi_i;
    tap_state_e        tap_st;
    rise_t             rise_d, rise_q;
    fall_t             fall_d, fall_q;
    dr_sel_e           dr_sel;
    logic              ext_mode, hiz_mode;
    logic              bsr_so, ser_out;
    logic [IR_W-1:0]   ir_cur;
    logic [N_BIDI-1:0] ext_data, ext_oe;

    if (PULLUP_EN) begin : g_pullup
        assign tms_i = (tms === 1'b0) ? 1'b0 : 1'b1;
        assign tdi_i = (tdi === 1'b0) ? 1'b0 : 1'b1;
    end else begin : g_plain
        assign tms_i = tms;
        assign tdi_i = tdi;
    end

    bscan_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms_i),
        .state (tap_st)
    );

    assign ir_cur = fall_q.ir;

    always_comb begin
        dr_sel   = DR_BYPASS;
        ext_mode = 1'b0;
        hiz_mode = 1'b0;
        case (ir_cur)
            OP_EXTEST: begin dr_sel = DR_BOUNDARY; ext_mode = 1'b1; end
            OP_SAMPLE: dr_sel = DR_BOUNDARY;
            OP_IDCODE: dr_sel = DR_IDENT;
            OP_HIGHZ:  hiz_mode = 1'b1;
            default:   dr_sel = DR_BYPASS;
        endcase
    end

    always_comb begin
        rise_d = rise_q;
        case (tap_st)
            ST_CAP_IR: rise_d.ir_sh = IR_CAPTURE;
            ST_SH_IR:  rise_d.ir_sh = {tdi_i, rise_q.ir_sh[IR_W-1:1]};
            ST_CAP_DR: begin
                rise_d.idsr = ID_WORD;
                rise_d.byp  = 1'b0;
            end
            ST_SH_DR: begin
                rise_d.idsr = {tdi_i, rise_q.idsr[31:1]};
                rise_d.byp  = tdi_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) rise_q <= '{ir_sh: IR_CAPTURE, idsr: ID_WORD, byp: 1'b0};
        else        rise_q <= rise_d;
    end

    always_comb begin
        if (tap_st == ST_SH_IR) ser_out = rise_q.ir_sh[0];
        else begin
            unique case (dr_sel)
                DR_IDENT:    ser_out = rise_q.idsr[0];
                DR_BOUNDARY: ser_out = bsr_so;
                default:     ser_out = rise_q.byp;
            endcase
        end
    end

    always_comb begin
        fall_d        = fall_q;
        fall_d.tdo    = ser_out;
        fall_d.tdo_en = (tap_st == ST_SH_IR) || (tap_st == ST_SH_DR);
        if (tap_st == ST_RESET)       fall_d.ir = OP_IDCODE;
        else if (tap_st == ST_UPD_IR) fall_d.ir = rise_q.ir_sh;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) fall_q <= '{ir: OP_IDCODE, tdo: 1'b0, tdo_en: 1'b0};
        else        fall_q <= fall_d;
    end

    bscan_cells #(
        .N_IN   (N_IN),
        .N_BIDI (N_BIDI)
    ) u_cells (
        .tck      (tck),
        .por_n    (por_n),
        .cap_en   (tap_st == ST_CAP_DR && dr_sel == DR_BOUNDARY),
        .shift_en (tap_st == ST_SH_DR  && dr_sel == DR_BOUNDARY),
        .upd_en   (tap_st == ST_UPD_DR && dr_sel == DR_BOUNDARY),
        .ext_mode (ext_mode),
        .hiz_mode (hiz_mode),
        .tdi      (tdi_i),
        .in_pin   (in_pin),
        .bidi_in  (bidi_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .so       (bsr_so),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .upd_data (ext_data),
        .upd_oe   (ext_oe)
    );

    assign tdo    = fall_q.tdo;
    assign tdo_en = fall_q.tdo_en;

endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
    import bscan_pkg::*;
#(
    parameter int unsigned N_BIDI = 2
) (
    input logic              tck,
    input logic              por_n,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir,
    input logic              tdo_en,
    input logic [N_BIDI-1:0] pad_oe,
    input logic [N_BIDI-1:0] hold_dat,
    input logic [N_BIDI-1:0] hold_oe
);

    always @(posedge tck) begin
        if (!por_n) begin
            assert_por_reset_R1: assert (state == ST_RESET && !tdo_en)
                else $error("controller not held in reset");
        end
    end

    assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (!por_n)
        state == ST_RESET |=> ir == OP_IDCODE)
        else $error("IDCODE not restored by reset state");

    assert_update_only_R8: assert property (@(posedge tck) disable iff (!por_n)
        state != ST_UPD_DR |-> $stable({hold_oe, hold_dat}))
        else $error("update stage moved outside Update-DR");

    assert_highz_off_R9: assert property (@(posedge tck) disable iff (!por_n)
        ir == OP_HIGHZ |-> pad_oe == '0)
        else $error("pad enabled under HIGHZ");

    assert_tdo_shift_R10: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR))
        else $error("TDO driven outside shift");

endmodule

bind bscan_tap bscan_tap_chk #(.N_BIDI(N_BIDI)) u_chk (
    .tck      (tck),
    .por_n    (por_n),
    .state    (tap_st),
    .ir       (ir_cur),
    .tdo_en   (tdo_en),
    .pad_oe   (pad_oe),
    .hold_dat (ext_data),
    .hold_oe  (ext_oe)
);

// File: tb/bscan_tap_tb.sv
module bscan_tap_tb;

    localparam logic [31:0] ID_RAW = 32'h0A5C_1F3E;
    localparam logic [31:0] ID_EXP = {ID_RAW[31:1], 1'b1};

    logic       tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [1:0] in_pin = '0, bidi_in = '0, core_out = '0, core_oe = '0;
    logic       tdo, tdo_en;
    logic [1:0] pad_out, pad_oe;

    int    n_chk = 0, n_fail = 0;
    logic  exp_q[$];
    string tag_q[$];
    logic  mon_on = 1'b0;
    bit    done = 1'b0;

    bscan_tap #(.N_IN(2), .N_BIDI(2), .ID_CODE(ID_RAW), .PULLUP_EN(1'b1)) u_dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .in_pin(in_pin), .bidi_in(bidi_in), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #5 tck = ~tck;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(logic m, logic d, logic watch = 1'b0, logic e = 1'b0, string tag = "");
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        mon_on = watch;
        if (watch) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(posedge tck);
        mon_on = 1'b0;
    endtask

    // monitor: pops expected serial bits as the design presents them
    initial forever begin
        @(negedge tck);
        #4;
        if (mon_on) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {63'd0, tdo}, {63'd0, e});
            check("R10 tdo_en in shift", {63'd0, tdo_en}, 64'd1);
        end
    end

    task automatic go_shift(bit ir);
        tick(1'b1, 1'b0);
        if (ir) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic shift(int n, logic [63:0] din, logic [63:0] exp, string tag);
        for (int k = 0; k < n; k++)
            tick(k == n - 1, din[k], 1'b1, exp[k], tag);
    endtask

    task automatic scan(bit ir, int n, logic [63:0] din, logic [63:0] exp, string tag);
        go_shift(ir);
        shift(n, din, exp, tag);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        #2;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        core_out = 2'b01;
        core_oe  = 2'b10;
        #23;
        check("R1 tdo_en in reset", {63'd0, tdo_en}, 64'd0);
        check("R1 pad_oe core",  {62'd0, pad_oe},  {62'd0, core_oe});
        check("R1 pad_out core", {62'd0, pad_out}, {62'd0, core_out});
        @(negedge tck);
        por_n = 1'b1;
        tick(1'b0, 1'b0);
        #2;
        check("R10 tdo_en idle", {63'd0, tdo_en}, 64'd0);

        scan(1'b0, 32, 64'h0, {32'd0, ID_EXP}, "R4 idcode word");

        scan(1'b1, 4, 64'hF, 64'h1, "R3 capture-ir");
        scan(1'b0, 3, 64'b101, 64'b010, "R5 bypass");

        scan(1'b1, 4, 64'b0110, 64'h1, "R3 capture-ir");
        scan(1'b0, 3, 64'b011, 64'b110, "R5 unassigned opcode");

        in_pin   = 2'b10;
        bidi_in  = 2'b01;
        core_oe  = 2'b01;
        core_out = 2'b00;
        scan(1'b1, 4, 64'b0010, 64'h1, "R3 capture-ir");
        scan(1'b0, 6, 64'b110100, 64'b001110, "R6 sample capture");
        check("R7 pad_out core", {62'd0, pad_out}, 64'b00);
        check("R7 pad_oe core",  {62'd0, pad_oe},  64'b01);

        scan(1'b1, 4, 64'b0000, 64'h1, "R3 capture-ir");
        check("R8 extest pad_out", {62'd0, pad_out}, 64'b11);
        check("R8 extest pad_oe",  {62'd0, pad_oe},  64'b10);

        go_shift(1'b0);
        shift(6, 64'b000011, 64'b001110, "R6 extest capture");
        tick(1'b0, 1'b0);
        #2;
        check("R8 pad_out held in pause", {62'd0, pad_out}, 64'b11);
        check("R8 pad_oe held in pause",  {62'd0, pad_oe},  64'b10);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        #2;
        check("R8 pad_out after update", {62'd0, pad_out}, 64'b00);
        check("R8 pad_oe after update",  {62'd0, pad_oe},  64'b00);

        core_out = 2'b10;
        scan(1'b1, 4, 64'b0011, 64'h1, "R3 capture-ir");
        check("R9 highz pad_oe",  {62'd0, pad_oe},  64'b00);
        check("R9 highz pad_out", {62'd0, pad_out}, 64'b10);
        scan(1'b0, 2, 64'b01, 64'b10, "R9 highz bypass");

        go_shift(1'b0);
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        #2;
        check("R2 pad_oe back to core", {62'd0, pad_oe}, 64'b01);
        check("R10 tdo_en idle", {63'd0, tdo_en}, 64'd0);
        scan(1'b0, 32, 64'h0, {32'd0, ID_EXP}, "R2 idcode after tms reset");

        summary();
    end

endmodule